// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the timing reference for a two-output pulse-width modulator. The input clock passes through two prescalers in series. The first is a power-of-two divider and the second divides by an even number. Each prescaled tick advances a 16-bit counter against a programmable period, in one of four count modes: up, down, up-down or hold.

Downstream compare and action logic reads three things from the block: the current count, the count direction, and two single-cycle strobes. One strobe marks the tick on which the count sits at zero. The other marks the tick on which the count equals the period.

A plain write port holds three registers: a control word, a period and a phase value. A new period can take effect at once, or it can wait in a shadow copy until the next zero event. A sync pulse can force the phase value into the counter. A suspend input can pause counting, depending on a two-bit run-mode field.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, the direction output is 1, both strobes are low, the mode is hold, and the period and its shadow copy are all ones. The first tick in down mode therefore loads 0xFFFF.
- R2: In up mode (mode field 0, control bits 1:0) the count runs 0,1,…,P and then returns to 0, so zero events come every P+1 ticks. A count above P after a period change returns to 0 on the next tick.
- R3: In down mode (mode 1) the count runs P,…,1,0 and then reloads P, so zero events come every P+1 ticks, and the direction output is 0.
- R4: In up-down mode (mode 2) the count climbs to P and falls back to 0, turning at both ends, so one cycle lasts 2·P ticks. The direction output is 1 while climbing and 0 while falling.
- R5: In hold mode (mode 3) the count does not change and no strobe is raised.
- R6: The counter advances only on prescaled ticks. One tick comes every 2^N·H input cycles, where N is control bits 12:10 and H is 2·M, or 1 when M is 0, with M taken from control bits 9:7.
- R7: Every write to the control register restarts the prescaler. With a total divisor D, the first tick after the write falls D cycles after the write edge.
- R8: Control bit 3 selects how a period write takes effect. With the bit at 0 the value waits in a shadow copy and moves to the active period on the next zero event. With the bit at 1 it takes effect at once.
- R9: When control bit 2 is 1, a sync_in pulse loads the phase register into the count and loads control bit 13 into the direction, whatever the mode. When control bit 2 is 0, sync_in has no effect.
- R10: zero_evt and period_evt are each high for one clock cycle, on a tick where the counter advances and the count equals 0 or the active period respectively.
- R11: Control bits 15:14 are the run mode. With value 0, suspend_in pauses counting at once. With value 1, counting pauses only once the count is 0. With values 2 and 3, suspend_in is ignored.
- R12: The write address selects the register: 0 is control, 1 is period and 2 is phase. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 control, 1 period, 2 phase) |
| wr_data | input | CNT_W | Write data |
| sync_in | input | 1 | Phase load request |
| suspend_in | input | 1 | Pause request, gated by the run mode |
| count | output | CNT_W | Current counter value |
| count_up | output | 1 | 1 while the counter climbs |
| zero_evt | output | 1 | Strobe: count at zero on an advancing tick |
| period_evt | output | 1 | Strobe: count at period on an advancing tick |

## Verification
The hardest situations to reach are collisions. A counter in up-down mode can be caught mid-slope by an immediate period shrink, by a sync load that flips its direction, or by a suspend that only takes hold once the count reaches zero. A shadow load can also land on the same cycle as a new period write. Directed sequences cover each mode and divisor once. A long random phase then mixes frequent control, period and phase writes, using small periods and divisors so that wraps and reversals occur often, with random sync and suspend pulses. Every cycle of that phase is compared against a model in the bench.

// File: rtl/pwmtime_pkg.sv
package pwmtime_pkg;

   localparam int CTRL_W = 16;
   localparam int CDIV_W = 3;
   localparam int HDIV_W = 3;

   typedef enum logic [1:0] {
      CM_UP   = 2'd0,
      CM_DOWN = 2'd1,
      CM_UPDN = 2'd2,
      CM_HOLD = 2'd3
   } cmode_e;

   typedef struct packed {
      logic [1:0]        run_mode;
      logic              ph_dir;
      logic [CDIV_W-1:0] cdiv;
      logic [HDIV_W-1:0] hdiv;
      logic              prd_imm;
      logic              ph_en;
      cmode_e            mode;
   } tctl_t;

   localparam logic [1:0] A_CTRL  = 2'd0;
   localparam logic [1:0] A_PRD   = 2'd1;
   localparam logic [1:0] A_PHASE = 2'd2;

endpackage

// File: rtl/pwmtime_regs.sv
module pwmtime_regs
   import pwmtime_pkg::*;
#(
   parameter int               CNT_W   = 16,
   parameter logic [CNT_W-1:0] RST_PRD = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             shadow_ld,
   output tctl_t            ctrl,
   output logic [CNT_W-1:0] prd,
   output logic [CNT_W-1:0] phase,
   output logic             ctrl_wr
);

   logic [CNT_W-1:0] prd_sh;
   logic             prd_wr;
   logic             ph_wr;
   logic             spare_unused;

   assign ctrl_wr      = wr_en && (wr_addr == A_CTRL);
   assign prd_wr       = wr_en && (wr_addr == A_PRD);
   assign ph_wr        = wr_en && (wr_addr == A_PHASE);
   assign spare_unused = ^wr_data[6:4];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl.run_mode <= 2'd0;
         ctrl.ph_dir   <= 1'b0;
         ctrl.cdiv     <= '0;
         ctrl.hdiv     <= '0;
         ctrl.prd_imm  <= 1'b0;
         ctrl.ph_en    <= 1'b0;
         ctrl.mode     <= CM_HOLD;
         prd_sh        <= RST_PRD;
         prd           <= RST_PRD;
         phase         <= '0;
      end else begin
         if (ctrl_wr) begin
            ctrl.run_mode <= wr_data[15:14];
            ctrl.ph_dir   <= wr_data[13];
            ctrl.cdiv     <= wr_data[12:10];
            ctrl.hdiv     <= wr_data[9:7];
            ctrl.prd_imm  <= wr_data[3];
            ctrl.ph_en    <= wr_data[2];
            ctrl.mode     <= cmode_e'(wr_data[1:0]);
         end
         if (shadow_ld && !ctrl.prd_imm)
            prd <= prd_sh;
         if (prd_wr) begin
            prd_sh <= wr_data;
            if (ctrl.prd_imm)
               prd <= wr_data;
         end
         if (ph_wr)
            phase <= wr_data;
      end
   end

   assert_imm_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (prd_wr && ctrl.prd_imm) |=> (prd == $past(wr_data)));

   assert_shadow_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (shadow_ld && !ctrl.prd_imm) |=> (prd == $past(prd_sh)));

   assert_ctrl_only_on_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_wr) |=> $stable(ctrl));

endmodule

// File: rtl/pwmtime_prescale.sv
module pwmtime_prescale
   import pwmtime_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [CDIV_W-1:0] cdiv,
   input  logic [HDIV_W-1:0] hdiv,
   output logic              tick
);

   localparam int CW = (1 << CDIV_W) - 1;
   localparam int HW = $clog2(2 * ((1 << HDIV_W) - 1));

   logic [CW-1:0] c_q;
   logic [CW-1:0] c_last;
   logic [HW-1:0] h_q;
   logic [HW-1:0] h_last;
   logic          c_end;
   logic          h_end;

   always_comb begin
      c_last = '0;
      for (int i = 0; i < CW; i++)
         if (i < int'(cdiv))
            c_last[i] = 1'b1;
   end

   assign h_last = (hdiv == '0) ? '0 : HW'(2 * int'(hdiv) - 1);
   assign c_end  = (c_q == c_last);
   assign h_end  = (h_q == h_last);
   assign tick   = c_end && h_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_q <= '0;
         h_q <= '0;
      end else if (restart) begin
         c_q <= '0;
         h_q <= '0;
      end else if (c_end) begin
         c_q <= '0;
         h_q <= h_end ? '0 : h_q + 1'b1;
      end else begin
         c_q <= c_q + 1'b1;
      end
   end

   assert_tick_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !restart && ((cdiv != '0) || (hdiv != '0))) |=> !tick);

   assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && ((cdiv != '0) || (hdiv != '0))) |=> (!tick || ($past(tick) && !$stable(cdiv))) || !$stable(hdiv) || !$stable(cdiv));

endmodule

// File: rtl/pwmtime_counter.sv
module pwmtime_counter
   import pwmtime_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  cmode_e           mode,
   input  logic             ph_en,
   input  logic             ph_dir,
   input  logic [1:0]       run_mode,
   input  logic [CNT_W-1:0] prd,
   input  logic [CNT_W-1:0] phase,
   input  logic             sync_in,
   input  logic             suspend_in,
   output logic [CNT_W-1:0] cnt_q,
   output logic             count_up,
   output logic             zero_evt,
   output logic             per_evt
);

   logic [CNT_W-1:0] cnt_d;
   logic             dir_q;
   logic             dir_d;
   logic             halt;
   logic             step;
   logic             load;
   logic             at_zero;

   assign at_zero = (cnt_q == '0);
   assign halt    = suspend_in && ((run_mode == 2'd0) || ((run_mode == 2'd1) && at_zero));
   assign step    = tick && (mode != CM_HOLD) && !halt;
   assign load    = ph_en && sync_in;

   always_comb begin
      cnt_d = cnt_q;
      dir_d = dir_q;
      if (load) begin
         cnt_d = phase;
         dir_d = ph_dir;
      end else if (step) begin
         case (mode)
            CM_UP:   cnt_d = (cnt_q >= prd) ? '0 : cnt_q + 1'b1;
            CM_DOWN: cnt_d = at_zero ? prd : cnt_q - 1'b1;
            CM_UPDN: begin
               if (dir_q) begin
                  if (cnt_q >= prd) begin
                     dir_d = 1'b0;
                     cnt_d = at_zero ? '0 : cnt_q - 1'b1;
                  end else begin
                     cnt_d = cnt_q + 1'b1;
                  end
               end else if (at_zero) begin
                  dir_d = 1'b1;
                  cnt_d = (prd == '0) ? '0 : {{(CNT_W-1){1'b0}}, 1'b1};
               end else begin
                  cnt_d = cnt_q - 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dir_q <= 1'b1;
      end else begin
         cnt_q <= cnt_d;
         dir_q <= dir_d;
      end
   end

   always_comb begin
      case (mode)
         CM_UP:   count_up = 1'b1;
         CM_DOWN: count_up = 1'b0;
         default: count_up = dir_q;
      endcase
   end

   assign zero_evt = step && at_zero;
   assign per_evt  = step && (cnt_q == prd);

   assert_up_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == CM_UP) && step && !load && (cnt_q < prd)) |=> (cnt_q == $past(cnt_q) + 1'b1));

   assert_turn_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == CM_UPDN) && step && !load && !dir_q && at_zero) |=> dir_q);

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == CM_HOLD) && !load) |=> $stable(cnt_q));

   assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(cnt_q));

   assert_phase_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == $past(phase)));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
   import pwmtime_pkg::*;
#(
   parameter int               CNT_W   = 16,
   parameter logic [CNT_W-1:0] RST_PRD = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             sync_in,
   input  logic             suspend_in,
   output logic [CNT_W-1:0] count,
   output logic             count_up,
   output logic             zero_evt,
   output logic             period_evt
);

   if (CNT_W < CTRL_W) begin : g_bad_width
      $error("pwm_timebase: CNT_W must cover the control word");
   end

   tctl_t            ctrl;
   logic [CNT_W-1:0] prd;
   logic [CNT_W-1:0] phase;
   logic             ctrl_wr;
   logic             tick;

   pwmtime_regs #(
      .CNT_W   (CNT_W),
      .RST_PRD (RST_PRD)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .shadow_ld (zero_evt),
      .ctrl      (ctrl),
      .prd       (prd),
      .phase     (phase),
      .ctrl_wr   (ctrl_wr)
   );

   pwmtime_prescale u_prescale (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (ctrl_wr),
      .cdiv    (ctrl.cdiv),
      .hdiv    (ctrl.hdiv),
      .tick    (tick)
   );

   pwmtime_counter #(
      .CNT_W (CNT_W)
   ) u_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .mode       (ctrl.mode),
      .ph_en      (ctrl.ph_en),
      .ph_dir     (ctrl.ph_dir),
      .run_mode   (ctrl.run_mode),
      .prd        (prd),
      .phase      (phase),
      .sync_in    (sync_in),
      .suspend_in (suspend_in),
      .cnt_q      (count),
      .count_up   (count_up),
      .zero_evt   (zero_evt),
      .per_evt    (period_evt)
   );

   assert_single_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_evt && (prd != '0) && !sync_in) |=> !zero_evt);

endmodule

// File: tb/test_pwm_timebase.sv
module test_pwm_timebase;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_addr = 2'd0;
   logic [W-1:0] wr_data = '0;
   logic         sync_in = 1'b0;
   logic         suspend_in = 1'b0;
   logic [W-1:0] count;
   logic         count_up;
   logic         zero_evt;
   logic         period_evt;

   always #2 clk = ~clk;

   pwm_timebase #(.CNT_W(W)) i_pwm_timebase (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .sync_in    (sync_in),
      .suspend_in (suspend_in),
      .count      (count),
      .count_up   (count_up),
      .zero_evt   (zero_evt),
      .period_evt (period_evt)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   string cur_req = "R1";
   bit    cmp_on = 1'b0;

   // ---------------- reference model ----------------
   logic [1:0]   m_mode, m_fr;
   logic         m_phen, m_imm, m_phdir, m_dir;
   logic [2:0]   m_cdiv, m_hdiv;
   logic [W-1:0] m_prd_sh, m_prd, m_phase, m_cnt;
   int           m_pc;

   function automatic int m_div();
      return (1 << m_cdiv) * ((m_hdiv == 3'd0) ? 1 : 2 * int'(m_hdiv));
   endfunction

   function automatic bit m_run();
      bit halt;
      halt = suspend_in && ((m_fr == 2'd0) || ((m_fr == 2'd1) && (m_cnt == '0)));
      return (m_mode != 2'd3) && !halt;
   endfunction

   function automatic bit m_step();
      return (m_pc == m_div() - 1) && m_run();
   endfunction

   function automatic bit m_dir_out();
      if (m_mode == 2'd0) return 1'b1;
      if (m_mode == 2'd1) return 1'b0;
      return m_dir;
   endfunction

   always @(posedge clk) begin
      int           d;
      bit           tk, st;
      logic [W-1:0] nc, np;
      logic         nd;
      if (!rst_n) begin
         m_mode = 2'd3; m_fr = 2'd0; m_phen = 0; m_imm = 0; m_phdir = 0;
         m_cdiv = 0; m_hdiv = 0; m_prd_sh = '1; m_prd = '1; m_phase = '0;
         m_cnt = '0; m_dir = 1'b1; m_pc = 0;
      end else begin
         d  = m_div();
         tk = (m_pc == d - 1);
         st = tk && m_run();
         nc = m_cnt; nd = m_dir; np = m_prd;
         if (m_phen && sync_in) begin
            nc = m_phase; nd = m_phdir;
         end else if (st) begin
            case (m_mode)
               2'd0: nc = (m_cnt >= m_prd) ? '0 : m_cnt + 1;
               2'd1: nc = (m_cnt == '0) ? m_prd : m_cnt - 1;
               2'd2: begin
                  if (m_dir) begin
                     if (m_cnt >= m_prd) begin nd = 0; nc = (m_cnt == '0) ? '0 : m_cnt - 1; end
                     else nc = m_cnt + 1;
                  end else if (m_cnt == '0) begin
                     nd = 1; nc = (m_prd == '0) ? '0 : 1;
                  end else nc = m_cnt - 1;
               end
               default: ;
            endcase
         end
         if (st && (m_cnt == '0) && !m_imm) np = m_prd_sh;
         if (wr_en && wr_addr == 2'd0) m_pc = 0;
         else m_pc = tk ? 0 : m_pc + 1;
         if (wr_en && wr_addr == 2'd1) begin
            m_prd_sh = wr_data;
            if (m_imm) np = wr_data;
         end
         if (wr_en && wr_addr == 2'd2) m_phase = wr_data;
         if (wr_en && wr_addr == 2'd0) begin
            m_fr = wr_data[15:14]; m_phdir = wr_data[13]; m_cdiv = wr_data[12:10];
            m_hdiv = wr_data[9:7]; m_imm = wr_data[3]; m_phen = wr_data[2];
            m_mode = wr_data[1:0];
         end
         m_cnt = nc; m_dir = nd; m_prd = np;
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                      input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      #1;
      if (rst_n && cmp_on) begin
         chk(cur_req, 32'(count), 32'(m_cnt), "count vs model");
         chk(cur_req, 32'(count_up), 32'(m_dir_out()), "direction vs model");
         chk(cur_req, 32'(zero_evt), 32'(m_step() && (m_cnt == '0)), "zero_evt vs model");
         chk(cur_req, 32'(period_evt), 32'(m_step() && (m_cnt == m_prd)), "period_evt vs model");
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [15:0] ctl(input logic [1:0] mode, input logic imm,
      input logic phen, input logic phdir, input logic [2:0] cdiv, input logic [2:0] hdiv,
      input logic [1:0] fr);
      return {fr, phdir, cdiv, hdiv, 3'b000, imm, phen, mode};
   endfunction

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic gap(input int exp, input string req);
      int k;
      k = 0;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk); #1;
         if (zero_evt) break;
      end
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk); #1;
         k++;
         if (zero_evt) break;
      end
      chk(req, 32'(k), 32'(exp), "cycles between zero events");
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      logic [W-1:0] c0;
      int           ev_z, ev_p;
      int           seed_dummy;
      seed_dummy = $urandom(32'h5eed);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk("R1", 32'(count), 0, "reset count");
      chk("R1", 32'(count_up), 1, "reset direction");
      chk("R1", 32'(zero_evt), 0, "reset zero_evt");
      chk("R1", 32'(period_evt), 0, "reset period_evt");
      cmp_on = 1'b1;
      repeat (5) @(negedge clk);
      #1 chk("R1", 32'(count), 0, "frozen after reset");
      wr(2'd0, ctl(2'd1, 0, 0, 0, 3'd0, 3'd0, 2'd0));
      @(negedge clk); #1;
      chk("R1", 32'(count), 32'hFFFF, "reset period loaded in down mode");

      // R2 up mode
      cur_req = "R2";
      wr(2'd0, ctl(2'd3, 1, 0, 0, 3'd0, 3'd0, 2'd0));
      wr(2'd1, 16'd4);
      wr(2'd0, ctl(2'd0, 1, 0, 0, 3'd0, 3'd0, 2'd0));
      gap(5, "R2");

      // R3 down mode
      cur_req = "R3";
      wr(2'd0, ctl(2'd1, 1, 0, 0, 3'd0, 3'd0, 2'd0));
      gap(5, "R3");
      #1 chk("R3", 32'(count_up), 0, "down direction");

      // R4 up-down
      cur_req = "R4";
      wr(2'd0, ctl(2'd2, 1, 0, 0, 3'd0, 3'd0, 2'd0));
      gap(8, "R4");
      @(negedge clk); #1;
      chk("R4", 32'(count_up), 1, "climbing after zero");

      // R5 hold
      cur_req = "R5";
      wr(2'd0, ctl(2'd3, 1, 0, 0, 3'd0, 3'd0, 2'd0));
      #1 c0 = count;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk); #1;
         chk("R5", 32'(count), 32'(c0), "hold keeps count");
         chk("R5", 32'(zero_evt | period_evt), 0, "no strobe in hold");
      end

      // R6 prescaler divisors
      cur_req = "R6";
      wr(2'd1, 16'd3);
      wr(2'd0, ctl(2'd0, 1, 0, 0, 3'd1, 3'd2, 2'd0));
      gap(32, "R6");
      wr(2'd0, ctl(2'd0, 1, 0, 0, 3'd2, 3'd0, 2'd0));
      gap(16, "R6");
      wr(2'd0, ctl(2'd0, 1, 0, 0, 3'd0, 3'd3, 2'd0));
      gap(24, "R6");

      // R7 restart on control write (divisor 8, period 3)
      cur_req = "R7";
      wr(2'd0, ctl(2'd0, 1, 0, 0, 3'd1, 3'd2, 2'd0));
      wr(2'd0, ctl(2'd0, 1, 0, 0, 3'd1, 3'd2, 2'd0));
      #1 c0 = count;
      for (int i = 0; i < 7; i++) begin
         @(negedge clk); #1;
         chk("R7", 32'(count), 32'(c0), "no tick before divisor elapses");
      end
      @(negedge clk); #1;
      chk("R7", 32'(count), (c0 >= 3) ? 0 : 32'(c0) + 1, "first tick after restart");

      // R8 shadow then immediate
      cur_req = "R8";
      wr(2'd0, ctl(2'd0, 0, 0, 0, 3'd0, 3'd0, 2'd0));
      wr(2'd1, 16'd9);
      begin
         int k;
         k = 0;
         for (int i = 0; i < 50; i++) begin
            #1 if (zero_evt) break;
            @(negedge clk); k++;
         end
         chk("R8", 32'(k <= 4), 1, "old period kept until zero");
      end
      gap(10, "R8");
      wr(2'd0, ctl(2'd0, 1, 0, 0, 3'd0, 3'd0, 2'd0));
      wr(2'd1, 16'd2);
      gap(3, "R8");

      // R9 phase load
      cur_req = "R9";
      wr(2'd1, 16'd9);
      wr(2'd2, 16'd7);
      wr(2'd0, ctl(2'd2, 1, 1, 0, 3'd0, 3'd0, 2'd0));
      @(negedge clk); sync_in = 1'b1;
      @(negedge clk); sync_in = 1'b0;
      #1 chk("R9", 32'(count), 7, "phase loaded");
      chk("R9", 32'(count_up), 0, "direction from phase bit");
      @(negedge clk); #1 chk("R9", 32'(count), 6, "counts down after load");
      wr(2'd0, ctl(2'd3, 1, 0, 0, 3'd0, 3'd0, 2'd0));
      wr(2'd2, 16'd2);
      #1 c0 = count;
      @(negedge clk); sync_in = 1'b1;
      @(negedge clk); sync_in = 1'b0;
      #1 chk("R9", 32'(count), 32'(c0), "sync ignored when disabled");

      // R10 strobes
      cur_req = "R10";
      wr(2'd1, 16'd4);
      wr(2'd0, ctl(2'd0, 1, 0, 0, 3'd0, 3'd0, 2'd0));
      ev_z = 0; ev_p = 0;
      for (int i = 0; i < 25; i++) begin
         @(negedge clk); #1;
         ev_z += int'(zero_evt); ev_p += int'(period_evt);
      end
      chk("R10", 32'(ev_z), 5, "zero strobes in 25 cycles");
      chk("R10", 32'(ev_p), 5, "period strobes in 25 cycles");
      wr(2'd1, 16'd0);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); #1;
         chk("R10", 32'(zero_evt & period_evt), 1, "both strobes at period zero");
      end

      // R11 suspend handling
      cur_req = "R11";
      wr(2'd1, 16'd9);
      wr(2'd0, ctl(2'd0, 1, 0, 0, 3'd0, 3'd0, 2'd0));
      @(negedge clk); suspend_in = 1'b1;
      #1 c0 = count;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk); #1;
         chk("R11", 32'(count), 32'(c0), "run mode 0 pauses");
      end
      wr(2'd0, ctl(2'd0, 1, 0, 0, 3'd0, 3'd0, 2'd1));
      repeat (12) @(negedge clk);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk); #1;
         chk("R11", 32'(count), 0, "run mode 1 parks at zero");
      end
      wr(2'd0, ctl(2'd0, 1, 0, 0, 3'd0, 3'd0, 2'd2));
      gap(10, "R11");
      suspend_in = 1'b0;

      // R12 unused address
      cur_req = "R12";
      wr(2'd1, 16'd4);
      wr(2'd3, 16'd1);
      gap(5, "R12");
      wr(2'd3, 16'hFFFF);
      gap(5, "R12");

      // random mix
      cur_req = "R10";
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         wr_en      = ($urandom % 6) == 0;
         wr_addr    = 2'($urandom % 4);
         sync_in    = ($urandom % 16) == 0;
         suspend_in = ($urandom % 8) == 0;
         case (wr_addr)
            2'd0: wr_data = ctl(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                                3'($urandom % 3), 3'($urandom % 3), 2'($urandom));
            2'd1: wr_data = 16'($urandom % 16);
            2'd2: wr_data = 16'($urandom % 16);
            default: wr_data = 16'($urandom);
         endcase
      end
      @(negedge clk);
      wr_en = 1'b0; sync_in = 1'b0; suspend_in = 1'b0;
      repeat (4) @(negedge clk);
      #1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule